// File: doc/BRIEF.md
# Peripheral Register Slave with OR-Combinable Read Bus

This block is a slave register file for a simple processor peripheral bus. The master presents a 14-bit word address, a 16-bit write word, an active-high access strobe and a two-bit active-high byte write mask. The slave claims a window of four consecutive word addresses that starts at a base address set by a parameter. It holds one 16-bit register at each address in that window. The byte address the processor uses is twice the word address.

Reads are combinational. The addressed register appears on the read bus in the same cycle as the access. When the strobe is low, or the address falls outside the window, the read bus is driven to zero. Because of this, the read buses of any number of slaves at distinct bases can be merged with a plain OR. Writes are byte-granular and are captured on the next rising clock edge. All registers clear on reset.

Top module: `periph_reg_slave`

## Requirements
- R1: With `busEn` high and `busAddr` inside the window, `busRdata` shows the addressed register in the same cycle, with no clock edge in between.
- R2: With `busEn` high and `busAddr` inside the window, `busByteWe[0]=1` loads `busWdata[7:0]` into bits 7:0 and `busByteWe[1]=1` loads `busWdata[15:8]` into bits 15:8. The load happens at the next rising clock edge. A lane whose mask bit is 0 keeps its value.
- R3: `busRdata` is zero whenever `busEn` is low.
- R4: `busRdata` is zero when `busEn` is high and `busAddr` lies outside `BASE_ADDR` to `BASE_ADDR+3`.
- R5: An in-window access with `busByteWe = 2'b00` changes no register.
- R6: A write with `busEn` low, or with an out-of-window address, changes no register.
- R7: While `rst` is high, every register is zero, and reads return zero until the registers are written again.
- R8: Register k (k = 0..3) sits at word address `BASE_ADDR + k`, which is byte address `2*(BASE_ADDR + k)`.
- R9: Two slaves at different bases share one bus and have their read buses ORed. A write to one slave never appears in the other, and the slave that is not addressed drives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; writes are captured on its rising edge |
| rst | input | 1 | Active-high asynchronous reset; clears all registers |
| busAddr | input | 14 | Word address of the access |
| busWdata | input | 16 | Write data word |
| busEn | input | 1 | Active-high access strobe |
| busByteWe | input | 2 | Active-high byte write mask; bit 0 selects the low byte, bit 1 the high byte |
| busRdata | output | 16 | Combinational read data; zero unless this slave is addressed |

## Verification
Read data is due in the same cycle as the access. The bench drives each access just after a falling edge and samples the ORed read bus one nanosecond later, before the rising edge that could apply a write. The values it compares against are therefore the register contents from before that access. A write shows up only after the following rising edge, so its effect is checked by a read access in a later cycle. Reset clearing is checked by reads issued in the cycles after `rst` falls.

// File: rtl/periph_reg_slave_pkg.sv
package periph_reg_slave_pkg;
  localparam int IDX_MAX_W = 4;
  localparam int LANE_MAX  = 8;

  typedef struct packed {
    logic                 hit;
    logic [IDX_MAX_W-1:0] idx;
    logic [LANE_MAX-1:0]  wrLane;
  } slvStrobe_t;
endpackage

// File: rtl/periph_reg_slave_ctrl.sv
module periph_reg_slave_ctrl
  import periph_reg_slave_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int LANES = 2,
  parameter int NUM_REGS = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 14'h0040
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busEn,
  input  logic [LANES-1:0]  busByteWe,
  output slvStrobe_t        strobe
);
  logic [ADDR_W-1:0] offset;
  logic              inWindow;

  always_comb begin
    offset   = busAddr - BASE_ADDR;
    inWindow = (busAddr >= BASE_ADDR) && (offset < ADDR_W'(NUM_REGS));
    strobe   = '0;
    strobe.hit = busEn && inWindow;
    strobe.idx = offset[IDX_MAX_W-1:0];
    for (int l = 0; l < LANES; l++) begin
      strobe.wrLane[l] = busEn && inWindow && busByteWe[l];
    end
  end
endmodule

// File: rtl/periph_reg_slave_dp.sv
module periph_reg_slave_dp
  import periph_reg_slave_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  slvStrobe_t                 strobe,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] regFile [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          regFile[r][l*8 +: 8] <= '0;
        end else if (strobe.wrLane[l] && (int'(strobe.idx) == r)) begin
          regFile[r][l*8 +: 8] <= busWdata[l*8 +: 8];
        end
      end
    end
    assign regFlat[r*DATA_W +: DATA_W] = regFile[r];
  end

  always_comb begin
    busRdata = '0;
    if (strobe.hit) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (int'(strobe.idx) == r) busRdata = regFile[r];
      end
    end
  end
endmodule

// File: rtl/periph_reg_slave.sv
module periph_reg_slave
  import periph_reg_slave_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int NUM_REGS = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 14'h0040
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic                  busEn,
  input  logic [DATA_W/8-1:0]   busByteWe,
  output logic [DATA_W-1:0]     busRdata
);
  localparam int LANES = DATA_W / 8;

  slvStrobe_t                 strobe;
  logic [NUM_REGS*DATA_W-1:0] regFlat;

  periph_reg_slave_ctrl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .busAddr(busAddr), .busEn(busEn), .busByteWe(busByteWe), .strobe(strobe)
  );

  periph_reg_slave_dp #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .regFlat(regFlat)
  );
endmodule

// File: rtl/periph_reg_slave_chk.sv
module periph_reg_slave_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int NUM_REGS = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 14'h0040
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [DATA_W-1:0]          busWdata,
  input logic                       busEn,
  input logic [DATA_W/8-1:0]        busByteWe,
  input logic [DATA_W-1:0]          busRdata,
  input logic [NUM_REGS*DATA_W-1:0] regFlat
);
  logic [ADDR_W-1:0] off;
  logic              inWin;
  int                lastIdx;
  logic [DATA_W-1:0] lastWd;

  assign off   = busAddr - BASE_ADDR;
  assign inWin = (busAddr >= BASE_ADDR) && (off < ADDR_W'(NUM_REGS));

  always_ff @(posedge clk) begin
    lastIdx <= int'(off);
    lastWd  <= busWdata;
  end

  // R1
  read_same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (busEn && inWin) |-> busRdata == regFlat[int'(off)*DATA_W +: DATA_W]);

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !busEn |-> busRdata == '0);

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (busEn && !inWin) |-> busRdata == '0);

  // R2
  low_lane_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busEn && inWin && busByteWe[0]) |=> regFlat[lastIdx*DATA_W +: 8] == lastWd[7:0]);

  // R2
  high_lane_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busEn && inWin && busByteWe[1]) |=> regFlat[lastIdx*DATA_W+8 +: 8] == lastWd[15:8]);

  // R5
  no_lane_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busEn && busByteWe == '0) |=> $stable(regFlat));

  // R6
  unclaimed_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(busEn && inWin) |=> $stable(regFlat));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> regFlat == '0);
endmodule

bind periph_reg_slave periph_reg_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busWdata(busWdata), .busEn(busEn),
  .busByteWe(busByteWe), .busRdata(busRdata), .regFlat(regFlat)
);

// File: tb/tb_periph_reg_slave.sv
module tb_periph_reg_slave;
  localparam logic [13:0] BASE_A = 14'h0040;
  localparam logic [13:0] BASE_B = 14'h0100;

  typedef struct packed {
    logic        en;
    logic [13:0] addr;
    logic [15:0] wd;
    logic [1:0]  we;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 14'h0040, 16'h1234, 2'b11},  // full write A0 (R2)
    '{1'b1, 14'h0040, 16'h0000, 2'b00},  // read A0 (R1)
    '{1'b1, 14'h0041, 16'hABCD, 2'b01},  // low lane only (R2)
    '{1'b1, 14'h0041, 16'h5678, 2'b10},  // high lane only (R2)
    '{1'b1, 14'h0041, 16'h0000, 2'b00},  // read A1 -> 56CD
    '{1'b1, 14'h0043, 16'hFFFF, 2'b00},  // no lanes (R5)
    '{1'b1, 14'h0043, 16'h0000, 2'b00},  // read A3 -> 0
    '{1'b1, 14'h0100, 16'hBEEF, 2'b11},  // write B0 (R9)
    '{1'b1, 14'h0040, 16'h0000, 2'b00},  // A0 unchanged (R9)
    '{1'b1, 14'h0100, 16'h0000, 2'b00},  // read B0
    '{1'b0, 14'h0040, 16'hDEAD, 2'b11},  // strobe low (R3, R6)
    '{1'b1, 14'h0040, 16'h0000, 2'b00},  // A0 still 1234 (R6)
    '{1'b1, 14'h0044, 16'h7777, 2'b11},  // just past window (R4, R6)
    '{1'b1, 14'h0103, 16'h0000, 2'b00},  // read B3 -> 0
    '{1'b1, 14'h0042, 16'h0F0F, 2'b11},  // write A2 (R8)
    '{1'b1, 14'h0042, 16'h0000, 2'b00}   // read A2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        busEn = 1'b0;
  logic [1:0]  busByteWe = '0;
  logic [15:0] rdA, rdB, rdOr;
  logic [15:0] mA [4];
  logic [15:0] mB [4];
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  periph_reg_slave #(.BASE_ADDR(BASE_A)) dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWdata(busWdata),
    .busEn(busEn), .busByteWe(busByteWe), .busRdata(rdA));

  periph_reg_slave #(.BASE_ADDR(BASE_B)) dutB (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWdata(busWdata),
    .busEn(busEn), .busByteWe(busByteWe), .busRdata(rdB));

  assign rdOr = rdA | rdB;

  function automatic bit inA(logic [13:0] a);
    return (a >= BASE_A) && (a < BASE_A + 14'd4);
  endfunction
  function automatic bit inB(logic [13:0] a);
    return (a >= BASE_B) && (a < BASE_B + 14'd4);
  endfunction

  function automatic logic [15:0] expRead(logic en, logic [13:0] a);
    if (!en) return 16'h0;
    if (inA(a)) return mA[a - BASE_A];
    if (inB(a)) return mB[a - BASE_B];
    return 16'h0;
  endfunction

  function automatic string tagOf(logic en, logic [13:0] a);
    if (!en) return "R3";
    if (!inA(a) && !inB(a)) return "R4";
    return "R1/R2";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(logic en, logic [13:0] a, logic [15:0] wd, logic [1:0] we);
    if (!en) return;
    for (int l = 0; l < 2; l++) begin
      if (we[l]) begin
        if (inA(a)) mA[a - BASE_A][l*8 +: 8] = wd[l*8 +: 8];
        if (inB(a)) mB[a - BASE_B][l*8 +: 8] = wd[l*8 +: 8];
      end
    end
  endtask

  task automatic access(vec_t v, string tag);
    @(negedge clk);
    busEn = v.en; busAddr = v.addr; busWdata = v.wd; busByteWe = v.we;
    #1;
    check(tag, rdOr, expRead(v.en, v.addr));
    // R9: the slave not addressed drives zero
    if (inA(v.addr)) check("R9", rdB, 16'h0);
    if (inB(v.addr)) check("R9", rdA, 16'h0);
    @(posedge clk);
    modelWrite(v.en, v.addr, v.wd, v.we);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mA[i] = '0; mB[i] = '0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R7: reset state visible on the bus
    busEn = 1'b1; busAddr = BASE_A; #1;
    check("R7", rdOr, 16'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      access(VECS[i], tagOf(VECS[i].en, VECS[i].addr));
    end

    // R8: fill all four registers of both slaves and read each back at its word address
    for (int k = 0; k < 4; k++) begin
      access('{1'b1, BASE_A + 14'(k), 16'hA000 + 16'(k), 2'b11}, "R8");
      access('{1'b1, BASE_B + 14'(k), 16'hB000 + 16'(k), 2'b11}, "R8");
    end
    for (int k = 0; k < 4; k++) begin
      access('{1'b1, BASE_A + 14'(k), 16'h0, 2'b00}, "R8");
      access('{1'b1, BASE_B + 14'(k), 16'h0, 2'b00}, "R8");
    end
    // R4: one below the window
    access('{1'b1, BASE_A - 14'd1, 16'h5555, 2'b11}, "R4");

    // R7: reset mid-run clears every register
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin mA[i] = '0; mB[i] = '0; end
    for (int k = 0; k < 4; k++) begin
      access('{1'b1, BASE_A + 14'(k), 16'h0, 2'b00}, "R7");
      access('{1'b1, BASE_B + 14'(k), 16'h0, 2'b00}, "R7");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule